// File: doc/BRIEF.md
# Lead-Lag Delay Word Controller

This block is the digital control unit of an all-digital delay-locked loop. A phase detector outside the block reports whether the delayed clock leads or lags the reference. The block turns that flag into an N-bit control word for a digitally controlled delay line, and it splits that word evenly across the delay line's stages. The host first loads a start word taken from a period measurement. The block accepts the start word only if the initial delay sits between half a reference period and one and a half periods. This window keeps the loop away from the stuck state at zero delay and away from locking onto a multiple of the period.

Tracking runs in one of two modes. In sequential mode each decision moves the word by one LSB. In successive-approximation mode the word is resolved one bit per decision, MSB first. Before every decision the block waits a programmable number of reference-cycle ticks, so the new delay has time to reach the detector. Lock is declared after a programmed number of direction reversals in sequential mode, or after the last bit in the other mode. If the word hits zero or full scale and the detector still pushes outward, the word is held and a fault is raised instead. A small registered read port returns the word and a status byte.

Top module: `dll_step_ctrl`

## Requirements
- R1: In sequential mode each decision adds one to the word when pd_lead is 1 (output leads, more delay needed) and subtracts one when pd_lead is 0.
- R2: In approximation mode, starting tracking sets the word to 2^(WORD_W-1) with bit index WORD_W-1. Each decision keeps the trial bit when pd_lead is 1 and clears it when pd_lead is 0, then sets the next lower bit. Lock follows the decision on bit 0, so there are exactly WORD_W decisions.
- R3: Synchronous reset sets the word to 2^(WORD_W-1), locked and fault to 0 and the status register to 0.
- R4: A preset pulse is accepted only when 2*preset_word >= period_meas and 2*preset_word <= 3*period_meas. An accepted preset loads the word and clears the lock, the faults and the reject flag. A refused preset leaves the word unchanged and sets the reject flag (status bit 3).
- R5: A decision is taken only after settle_len step_tick pulses have arrived since the previous decision or since the start of tracking; a settle_len of 0 acts as 1. The word does not change between decisions.
- R6: A lag decision at word 0 raises fault and the low-error flag (status bit 1), and the word stays 0. A lead decision at full scale raises fault and the high-error flag (status bit 2), and the word stays at full scale. While the fault is held, further detector results are ignored.
- R7: In sequential mode, locked rises on the decision that brings the count of direction reversals to alt_target (0 acts as 1). While locked the word is frozen.
- R8: stage_codes slice k equals floor((word + k) / NSTAGE), so the NSTAGE slices differ by at most one and sum to the word.
- R9: A preset pulse overrides a decision due in the same cycle. The word takes the preset value, lock is cleared and tracking restarts from that word.
- R10: rd_data shows, one clock after rd_addr is applied, the word for address 0 and the status for address 1. Status bits: 0 locked, 1 low error, 2 high error, 3 preset refused, 4 last pd_lead, 5 tracking active. Other addresses read 0.
- R11: Dropping track_en returns the block to idle and clears locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_tick | input | 1 | One-cycle pulse per reference cycle |
| pd_lead | input | 1 | Phase detector: 1 = output leads, 0 = lags |
| track_en | input | 1 | Enables tracking |
| sar_mode | input | 1 | 1 = approximation mode, 0 = sequential |
| settle_len | input | SETTLE_W | Ticks to wait before each decision |
| alt_target | input | ALT_W | Reversals needed for sequential lock |
| preset_load | input | 1 | Preset strobe |
| preset_word | input | WORD_W | Start word to load |
| period_meas | input | WORD_W | Measured reference period in word LSBs |
| rd_addr | input | 2 | Read address |
| delay_word | output | WORD_W | Control word to the delay line |
| stage_codes | output | NSTAGE*STAGE_W | Per-stage share of the word |
| locked | output | 1 | Lock flag |
| fault | output | 1 | Word limit reached |
| rd_data | output | WORD_W | Registered read data |

## Verification
The bench closes the loop with a delay-line model whose lead/lag answer depends on the word. It walks both modes to the same lock word, so a design that inverts the step direction or resolves bits LSB first ends on the wrong word or never locks. The bench counts reference ticks until lock, which exposes a controller that samples the detector without waiting the settle count, or that treats a count of zero as an endless wait. It drives both word limits, where a wrapping counter would jump to the far end instead of holding and flagging. It probes both edges of the preset window, where an off-by-one comparison would accept or refuse the wrong value. It also fires a preset in the same cycle as a due decision, so a design that gives tracking priority shows a stepped word.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOCKED = 2'd2,
    ST_FAULT  = 2'd3
  } trk_state_e;

  // status register, bit 0 is locked
  typedef struct packed {
    logic tracking;
    logic last_lead;
    logic preset_rej;
    logic err_high;
    logic err_low;
    logic locked;
  } status_t;

  localparam int STATUS_W = 6;

endpackage

// File: rtl/dll_settle_timer.sv
module dll_settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] length,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [CNT_W-1:0] eff_len;

  assign eff_len = (length == '0) ? CNT_W'(1) : length;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= eff_len;
    end else if (run_q && tick) begin
      if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
      else                    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = run_q && tick && (cnt_q == CNT_W'(1));

  // R5: a running wait never holds a zero count
  a_r5_cnt_nonzero: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0));

endmodule

// File: rtl/dll_preset_check.sv
module dll_preset_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] start_word,
  input  logic [W-1:0] period_word,
  output logic         in_window
);

  logic [W+1:0] twice_start;
  logic [W+1:0] period_ext;
  logic [W+1:0] thrice_period;

  assign twice_start   = {1'b0, start_word, 1'b0};
  assign period_ext    = {2'b00, period_word};
  assign thrice_period = period_ext + {1'b0, period_word, 1'b0};
  assign in_window     = (twice_start >= period_ext) && (twice_start <= thrice_period);

endmodule

// File: rtl/dll_stage_split.sv
module dll_stage_split #(
  parameter int W      = 8,
  parameter int NSTAGE = 8,
  parameter int SW     = W + 1 - $clog2(NSTAGE)
) (
  input  logic [W-1:0]         word,
  output logic [NSTAGE*SW-1:0] codes
);

  localparam int LOG_N = $clog2(NSTAGE);

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    logic [W:0] biased;
    assign biased = {1'b0, word} + (W+1)'(k);
    assign codes[k*SW +: SW] = SW'(biased >> LOG_N);
  end

endmodule

// File: rtl/dll_step_ctrl.sv
module dll_step_ctrl
  import dll_ctrl_pkg::*;
#(
  parameter  int WORD_W   = 8,
  parameter  int SETTLE_W = 4,
  parameter  int ALT_W    = 4,
  parameter  int NSTAGE   = 8,
  localparam int STAGE_W  = WORD_W + 1 - $clog2(NSTAGE)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      step_tick,
  input  logic                      pd_lead,
  input  logic                      track_en,
  input  logic                      sar_mode,
  input  logic [SETTLE_W-1:0]       settle_len,
  input  logic [ALT_W-1:0]          alt_target,
  input  logic                      preset_load,
  input  logic [WORD_W-1:0]         preset_word,
  input  logic [WORD_W-1:0]         period_meas,
  input  logic [1:0]                rd_addr,
  output logic [WORD_W-1:0]         delay_word,
  output logic [NSTAGE*STAGE_W-1:0] stage_codes,
  output logic                      locked,
  output logic                      fault,
  output logic [WORD_W-1:0]         rd_data
);

  localparam int                IDX_W    = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] WORD_MID = WORD_W'(1) << (WORD_W - 1);
  localparam logic [WORD_W-1:0] WORD_MAX = '1;

  trk_state_e        state_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sar_q;
  logic              lock_q, err_lo_q, err_hi_q, rej_q;
  logic              last_lead_q, have_dir_q;
  logic [ALT_W-1:0]  alt_q;

  logic              preset_ok;
  logic              settle_done;
  logic              timer_start;
  logic              decide;

  logic [WORD_W-1:0] dec_word;
  logic [IDX_W-1:0]  dec_idx;
  logic [ALT_W-1:0]  dec_alt;
  logic [ALT_W-1:0]  alt_goal;
  logic              dec_lock, dec_err_lo, dec_err_hi;
  status_t           status;

  dll_preset_check #(.W(WORD_W)) preset_i (
    .start_word (preset_word),
    .period_word(period_meas),
    .in_window  (preset_ok)
  );

  dll_settle_timer #(.CNT_W(SETTLE_W)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .start (timer_start),
    .tick  (step_tick),
    .length(settle_len),
    .done  (settle_done)
  );

  dll_stage_split #(.W(WORD_W), .NSTAGE(NSTAGE), .SW(STAGE_W)) split_i (
    .word (word_q),
    .codes(stage_codes)
  );

  assign alt_goal = (alt_target == '0) ? ALT_W'(1) : alt_target;
  assign decide   = (state_q == ST_SETTLE) && track_en && settle_done && !preset_load;

  // next word for one decision
  always_comb begin
    dec_word   = word_q;
    dec_idx    = idx_q;
    dec_alt    = alt_q;
    dec_lock   = 1'b0;
    dec_err_lo = 1'b0;
    dec_err_hi = 1'b0;
    if (sar_q) begin
      dec_word[idx_q] = pd_lead;
      if (idx_q == '0) begin
        dec_lock = 1'b1;
      end else begin
        dec_word[idx_q - 1'b1] = 1'b1;
        dec_idx = idx_q - 1'b1;
      end
    end else begin
      if (pd_lead) begin
        if (word_q == WORD_MAX) dec_err_hi = 1'b1;
        else                    dec_word = word_q + 1'b1;
      end else begin
        if (word_q == '0) dec_err_lo = 1'b1;
        else              dec_word = word_q - 1'b1;
      end
      if (!dec_err_lo && !dec_err_hi && have_dir_q && (pd_lead != last_lead_q)) begin
        if (alt_q != '1) dec_alt = alt_q + 1'b1;
        if (dec_alt >= alt_goal) dec_lock = 1'b1;
      end
    end
  end

  assign timer_start = !preset_load && track_en &&
                       ((state_q == ST_IDLE) ||
                        (decide && !dec_lock && !dec_err_lo && !dec_err_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      word_q      <= WORD_MID;
      idx_q       <= '0;
      sar_q       <= 1'b0;
      lock_q      <= 1'b0;
      err_lo_q    <= 1'b0;
      err_hi_q    <= 1'b0;
      rej_q       <= 1'b0;
      last_lead_q <= 1'b0;
      have_dir_q  <= 1'b0;
      alt_q       <= '0;
    end else if (preset_load) begin
      state_q <= ST_IDLE;
      lock_q  <= 1'b0;
      if (preset_ok) begin
        word_q   <= preset_word;
        err_lo_q <= 1'b0;
        err_hi_q <= 1'b0;
        rej_q    <= 1'b0;
      end else begin
        rej_q <= 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (track_en) begin
            state_q    <= ST_SETTLE;
            sar_q      <= sar_mode;
            have_dir_q <= 1'b0;
            alt_q      <= '0;
            lock_q     <= 1'b0;
            if (sar_mode) begin
              word_q <= WORD_MID;
              idx_q  <= IDX_W'(WORD_W - 1);
            end
          end
        end
        ST_SETTLE: begin
          if (!track_en) begin
            state_q <= ST_IDLE;
          end else if (settle_done) begin
            last_lead_q <= pd_lead;
            have_dir_q  <= 1'b1;
            word_q      <= dec_word;
            idx_q       <= dec_idx;
            alt_q       <= dec_alt;
            if (dec_err_lo || dec_err_hi) begin
              state_q  <= ST_FAULT;
              err_lo_q <= dec_err_lo;
              err_hi_q <= dec_err_hi;
            end else if (dec_lock) begin
              state_q <= ST_LOCKED;
              lock_q  <= 1'b1;
            end
          end
        end
        ST_LOCKED: begin
          if (!track_en) begin
            state_q <= ST_IDLE;
            lock_q  <= 1'b0;
          end
        end
        ST_FAULT: begin
          if (!track_en) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    status.tracking   = (state_q == ST_SETTLE);
    status.last_lead  = last_lead_q;
    status.preset_rej = rej_q;
    status.err_high   = err_hi_q;
    status.err_low    = err_lo_q;
    status.locked     = lock_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        2'd0:    rd_data <= word_q;
        2'd1:    rd_data <= {{(WORD_W-STATUS_W){1'b0}}, status};
        default: rd_data <= '0;
      endcase
    end
  end

  assign delay_word = word_q;
  assign locked     = lock_q;
  assign fault      = err_lo_q | err_hi_q;

  function automatic int code_sum(input logic [NSTAGE*STAGE_W-1:0] c);
    int s;
    s = 0;
    for (int k = 0; k < NSTAGE; k++) s += int'(c[k*STAGE_W +: STAGE_W]);
    return s;
  endfunction

  // R1: lead grows the word by one, lag shrinks it by one
  a_r1_lead_up: assert property (@(posedge clk) disable iff (rst)
    (decide && !sar_q && pd_lead && word_q != WORD_MAX) |=> (word_q == $past(word_q) + 1'b1));
  a_r1_lag_down: assert property (@(posedge clk) disable iff (rst)
    (decide && !sar_q && !pd_lead && word_q != '0) |=> (word_q == $past(word_q) - 1'b1));

  // R2: approximation starts from the MSB alone
  a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && track_en && sar_mode && !preset_load) |=> (word_q == WORD_MID));

  // R4: an unrefused preset lies inside the window
  a_r4_preset_window: assert property (@(posedge clk) disable iff (rst)
    preset_load |=> (rej_q ||
      ((2 * int'(word_q) >= int'($past(period_meas))) &&
       (2 * int'(word_q) <= 3 * int'($past(period_meas))))));

  // R5: no word change between ticks while waiting
  a_r5_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SETTLE && !step_tick && !preset_load) |=> $stable(word_q));

  // R6: limits hold instead of wrapping
  a_r6_low_clamp: assert property (@(posedge clk) disable iff (rst)
    $rose(err_lo_q) |-> (word_q == '0));
  a_r6_high_clamp: assert property (@(posedge clk) disable iff (rst)
    $rose(err_hi_q) |-> (word_q == WORD_MAX));

  // R7: a locked word stays put
  a_r7_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !preset_load) |=> $stable(word_q));

  // R8: stage shares add up to the word
  a_r8_split_sum: assert property (@(posedge clk) disable iff (rst)
    code_sum(stage_codes) == int'(word_q));

endmodule

// File: tb/dll_step_ctrl_tb.sv
module dll_step_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 8;
  localparam int SETTLE_W   = 4;
  localparam int ALT_W      = 4;
  localparam int NSTAGE     = 8;
  localparam int STAGE_W    = WORD_W + 1 - $clog2(NSTAGE);
  localparam int TICK_DIV   = 4;
  localparam int WDOG       = 150000;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic                      step_tick = 1'b0;
  logic                      pd_lead;
  logic                      track_en = 1'b0;
  logic                      sar_mode = 1'b0;
  logic [SETTLE_W-1:0]       settle_len = '0;
  logic [ALT_W-1:0]          alt_target = '0;
  logic                      preset_load = 1'b0;
  logic [WORD_W-1:0]         preset_word = '0;
  logic [WORD_W-1:0]         period_meas = '0;
  logic [1:0]                rd_addr = '0;
  logic [WORD_W-1:0]         delay_word;
  logic [NSTAGE*STAGE_W-1:0] stage_codes;
  logic                      locked;
  logic                      fault;
  logic [WORD_W-1:0]         rd_data;

  int n_checks = 0;
  int n_bad    = 0;
  int tick_total = 0;
  int model_target = 100;
  bit finished = 1'b0;

  // behavioural delay line: output leads while the delay is short of one period
  assign pd_lead = (int'(delay_word) < model_target);

  dll_step_ctrl #(
    .WORD_W(WORD_W), .SETTLE_W(SETTLE_W), .ALT_W(ALT_W), .NSTAGE(NSTAGE)
  ) dut_i (
    .clk(clk), .rst(rst), .step_tick(step_tick), .pd_lead(pd_lead),
    .track_en(track_en), .sar_mode(sar_mode), .settle_len(settle_len),
    .alt_target(alt_target), .preset_load(preset_load), .preset_word(preset_word),
    .period_meas(period_meas), .rd_addr(rd_addr), .delay_word(delay_word),
    .stage_codes(stage_codes), .locked(locked), .fault(fault), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) begin
        @(negedge clk);
        step_tick = 1'b0;
      end
      @(negedge clk);
      step_tick = 1'b1;
      tick_total++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic do_preset(input int w, input int p);
    @(negedge clk);
    preset_word = WORD_W'(w);
    period_meas = WORD_W'(p);
    preset_load = 1'b1;
    @(negedge clk);
    preset_load = 1'b0;
  endtask

  task automatic wait_stop(input int max_cyc, output bit got);
    got = 1'b0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (locked || fault) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic check_split(input string tag);
    int s;
    s = 0;
    for (int k = 0; k < NSTAGE; k++) begin
      int exp_c;
      int act_c;
      exp_c = (int'(delay_word) + k) / NSTAGE;
      act_c = int'(stage_codes[k*STAGE_W +: STAGE_W]);
      s += act_c;
      if (act_c != exp_c) begin
        chk(1'b0, tag, act_c, exp_c);
        return;
      end
    end
    chk(s == int'(delay_word), tag, s, int'(delay_word));
  endtask

  task automatic t_reset;
    int v;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(delay_word == 8'd128, "R3 reset word", int'(delay_word), 128);
    chk(!locked && !fault, "R3 reset flags", int'({locked, fault}), 0);
    read_reg(2'd1, v);
    chk(v == 0, "R3 R10 reset status", v, 0);
    check_split("R8 split at reset");
  endtask

  task automatic t_preset_window;
    int v;
    do_preset(100, 100);
    do_preset(40, 100);
    chk(delay_word == 8'd100, "R4 low refuse keeps word", int'(delay_word), 100);
    read_reg(2'd1, v);
    chk(v == 8, "R4 R10 refuse flag bit3", v, 8);
    do_preset(50, 100);
    chk(delay_word == 8'd50, "R4 half-period edge accepted", int'(delay_word), 50);
    read_reg(2'd1, v);
    chk(v == 0, "R4 accept clears refuse", v, 0);
    do_preset(150, 100);
    chk(delay_word == 8'd150, "R4 1.5-period edge accepted", int'(delay_word), 150);
    do_preset(151, 100);
    chk(delay_word == 8'd150, "R4 above window refused", int'(delay_word), 150);
    do_preset(49, 100);
    chk(delay_word == 8'd150, "R4 below window refused", int'(delay_word), 150);
    read_reg(2'd0, v);
    chk(v == 150, "R10 word read", v, 150);
  endtask

  task automatic t_seq_track;
    int v;
    int t0;
    int dt;
    bit got;
    model_target = 100;
    sar_mode = 1'b0;
    settle_len = 4'd2;
    alt_target = 4'd3;
    do_preset(95, 100);
    @(negedge clk);
    t0 = tick_total;
    track_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (delay_word != 8'd95) break;
    end
    chk(delay_word == 8'd96, "R1 lead steps up by one", int'(delay_word), 96);
    wait_stop(2000, got);
    dt = tick_total - t0;
    chk(got && locked, "R7 sequential lock reached", int'(locked), 1);
    chk(delay_word == 8'd99, "R1 R7 sequential lock word", int'(delay_word), 99);
    chk(dt >= 16 && dt <= 18, "R5 two ticks per decision", dt, 16);
    check_split("R8 split at lock");
    repeat (40) @(negedge clk);
    chk(delay_word == 8'd99, "R7 word frozen while locked", int'(delay_word), 99);
    read_reg(2'd1, v);
    chk(v == 1, "R10 status when locked", v, 1);
    @(negedge clk);
    track_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!locked, "R11 lock cleared on disable", int'(locked), 0);
  endtask

  task automatic t_sar_track;
    int t0;
    int dt;
    bit got;
    model_target = 100;
    sar_mode = 1'b1;
    settle_len = 4'd1;
    @(negedge clk);
    t0 = tick_total;
    track_en = 1'b1;
    @(negedge clk);
    chk(delay_word == 8'd128, "R2 trial starts at MSB", int'(delay_word), 128);
    wait_stop(2000, got);
    dt = tick_total - t0;
    chk(got && locked, "R2 approximation lock", int'(locked), 1);
    chk(delay_word == 8'd99, "R2 approximation result", int'(delay_word), 99);
    chk(dt >= 8 && dt <= 10, "R2 R5 one decision per bit", dt, 8);
    @(negedge clk);
    track_en = 1'b0;
    sar_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_clamp_low;
    int v;
    int t0;
    int dt;
    bit got;
    model_target = 0;
    settle_len = 4'd0;
    do_preset(3, 6);
    @(negedge clk);
    t0 = tick_total;
    track_en = 1'b1;
    wait_stop(2000, got);
    dt = tick_total - t0;
    chk(got && fault, "R6 low limit fault", int'(fault), 1);
    chk(delay_word == 8'd0, "R6 word held at zero", int'(delay_word), 0);
    chk(dt >= 4 && dt <= 5, "R5 zero settle acts as one", dt, 4);
    repeat (20) @(negedge clk);
    chk(delay_word == 8'd0, "R6 lag ignored after fault", int'(delay_word), 0);
    read_reg(2'd1, v);
    chk(v == 2, "R6 R10 low error status", v, 2);
    @(negedge clk);
    track_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_clamp_high;
    int v;
    bit got;
    model_target = 1000;
    settle_len = 4'd1;
    do_preset(250, 200);
    @(negedge clk);
    track_en = 1'b1;
    wait_stop(2000, got);
    chk(got && fault, "R6 high limit fault", int'(fault), 1);
    chk(delay_word == 8'd255, "R6 word held at full scale", int'(delay_word), 255);
    check_split("R8 split at full scale");
    read_reg(2'd1, v);
    chk(v == 20, "R6 R10 high error status", v, 20);
    @(negedge clk);
    track_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_priority;
    model_target = 200;
    settle_len = 4'd1;
    do_preset(60, 100);
    @(negedge clk);
    track_en = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (delay_word >= 8'd63) break;
    end
    // wait for a tick, then strobe preset so both land on one edge
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick_total % 1 == 0 && step_tick) break;
    end
    @(negedge clk);
    while (step_tick == 1'b1) @(negedge clk);
    repeat (TICK_DIV - 1) @(negedge clk);
    preset_word = 8'd70;
    period_meas = 8'd100;
    preset_load = 1'b1;
    @(negedge clk);
    preset_load = 1'b0;
    chk(delay_word == 8'd70, "R9 preset beats due decision", int'(delay_word), 70);
    chk(!locked, "R9 lock cleared by preset", int'(locked), 0);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (delay_word != 8'd70) break;
    end
    chk(delay_word == 8'd71, "R9 tracking resumes from preset", int'(delay_word), 71);
    track_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_preset_window();
    t_seq_track();
    t_sar_track();
    t_clamp_low();
    t_clamp_high();
    t_priority();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, 0);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule